// File: doc/BRIEF.md
# PWM Configuration Register Port over SPI

This block is an SPI slave that holds the configuration of a four-channel PWM output stage. A host sends one 16-bit frame per chip-select window. The upper byte of the frame is an address byte and the lower byte is a data byte. Depending on two flag bits, the frame either writes a register or asks for a register's contents. The answer comes back in the frame that follows.

The registers drive parallel outputs to the PWM engine: an operating mode field with a decoded "normal" flag, per-channel output inversion, per-channel enables, an 8-bit frequency code and an 8-bit duty code for each channel, and a watchdog byte that is only stored. The SPI pins are brought into the system clock domain through two-stage synchronizers, so the serial clock must be several times slower than the system clock. The block uses SPI mode 0: MOSI is sampled on rising SCLK, MISO changes on falling SCLK, and the most significant bit goes first.

Top module: `pwm_spi_regs`

## Requirements
- R1: After a synchronous active-low reset every register is zero: mode 0 (not normal), no inversion, all channels disabled, frequency, duty and watchdog codes zero, and MISO low.
- R2: A frame whose bit 15 (address byte bit 7) is set writes data byte bits [7:0] into the register indexed by frame bits [14:8]. The new value appears on the outputs once chip select has gone high.
- R3: A frame with bit 15 clear and bit 7 set is a read request. The next frame shifts out a 16-bit word whose bits [13:0] carry the register value zero-extended and whose bits [15:14] are zero.
- R4: The frame that follows a write frame, or a frame with neither flag set, shifts out all zeros.
- R5: A chip-select window with fewer or more than 16 rising SCLK edges changes no register and leaves the pending response unchanged.
- R6: Writes to indices other than 0x00, 0x05, 0x07, 0x08–0x0F and 0x14 change no output. Reads of those other indices return zero.
- R7: In the inversion register at index 0x05, bit n-1 inverts channel n. In the enable register at index 0x07, bit 4+n-1 enables channel n.
- R8: Index 0x00 holds the mode in bits [7:6]. The normal flag is high exactly when that field equals 1.
- R9: MOSI is sampled on the rising SCLK edge and MISO changes after the falling edge, both MSB first. The first response bit is valid before the first rising edge.
- R10: The frequency code of channel n sits at index 0x08+n-1 and its duty code at 0x0C+n-1. Each appears in byte n-1 of its flattened output bus.
- R11: A frame with both bit 15 and bit 7 set is a write, and bit 7 is stored as data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host, idle low |
| spi_cs_n | input | 1 | Chip select, active low, one frame per window |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, low while deselected |
| mode_o | output | 2 | Operating mode field |
| normal_o | output | 1 | High when the mode field equals 1 |
| pol_inv_o | output | 4 | Per-channel output inversion |
| ch_en_o | output | 4 | Per-channel enable |
| freq_o | output | 32 | Frequency codes, channel n in byte n-1 |
| duty_o | output | 32 | Duty codes, channel n in byte n-1 |
| wdog_o | output | 8 | Stored watchdog byte |

## Verification
The hardest situation to reach is a malformed frame arriving while a read response is still pending. The stimulus first issues a read request. It then sends a 12-clock frame and a 20-clock frame, each holding a valid-looking write. Finally it sends a proper frame and checks two things: the outputs are unchanged, and that last frame still returns the value that was read before the bad frames. Response sequencing is exercised by chaining read, read, write and no-op frames back to back, so that each returned word shows which frame the response belongs to.

// File: rtl/pwm_spi_pkg.sv
// Package: shared constants for the PWM configuration SPI port.
// Assumes a 16-bit frame of address byte over data byte.
package pwm_spi_pkg;
    localparam int FRAME_W  = 16;
    localparam int DATA_W   = 8;
    localparam int IDX_W    = 7;
    localparam int RESP_W   = 14;
    localparam int N_CH     = 4;
    localparam int CNT_W    = $clog2(FRAME_W + 2);
    localparam int WR_BIT   = FRAME_W - 1;
    localparam int RD_BIT   = DATA_W - 1;

    localparam logic [IDX_W-1:0] IDX_GLOBAL    = 7'h00;
    localparam logic [IDX_W-1:0] IDX_POLARITY  = 7'h05;
    localparam logic [IDX_W-1:0] IDX_ENABLE    = 7'h07;
    localparam logic [IDX_W-1:0] IDX_FREQ_BASE = 7'h08;
    localparam logic [IDX_W-1:0] IDX_DUTY_BASE = 7'h0C;
    localparam logic [IDX_W-1:0] IDX_WATCHDOG  = 7'h14;

    localparam logic [1:0] MODE_NORMAL = 2'd1;
endpackage

// File: rtl/pwm_spi_shifter.sv
// Module: pwm_spi_shifter
// Synchronises the SPI pins, shifts a mode-0 frame in and the pending
// response out, and flags a frame that saw exactly FRAME_W rising edges.
// Assumes SCLK runs at least four times slower than clk.
module pwm_spi_shifter
    import pwm_spi_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_i,
    input  logic               cs_n_i,
    input  logic               mosi_i,
    input  logic [FRAME_W-1:0] resp_i,
    output logic               miso_o,
    output logic               frame_ok_o,
    output logic [FRAME_W-1:0] frame_o
);
    logic [2:0] sck_s, cs_s;
    logic [1:0] mosi_s;
    logic [CNT_W-1:0] cnt_q;
    logic [FRAME_W-1:0] rx_q, tx_q;
    logic sck_rise, sck_fall, cs_fall, cs_rise, cs_act;

    // Purpose: bring asynchronous SPI pins into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s  <= '0;
            cs_s   <= '1;
            mosi_s <= '0;
        end else begin
            sck_s  <= {sck_s[1:0], sck_i};
            cs_s   <= {cs_s[1:0], cs_n_i};
            mosi_s <= {mosi_s[0], mosi_i};
        end
    end

    assign sck_rise = sck_s[1] & ~sck_s[2];
    assign sck_fall = ~sck_s[1] & sck_s[2];
    assign cs_fall  = ~cs_s[1] & cs_s[2];
    assign cs_rise  = cs_s[1] & ~cs_s[2];
    assign cs_act   = ~cs_s[1];

    // Purpose: count edges, shift receive and transmit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rx_q  <= '0;
            tx_q  <= '0;
        end else if (cs_fall) begin
            cnt_q <= '0;
            tx_q  <= resp_i;
        end else if (cs_act) begin
            if (sck_rise) begin
                rx_q  <= {rx_q[FRAME_W-2:0], mosi_s[1]};
                cnt_q <= (cnt_q == CNT_W'(FRAME_W + 1)) ? cnt_q : cnt_q + 1'b1;
            end
            if (sck_fall) begin
                tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
            end
        end
    end

    // Purpose: flag a complete frame when chip select returns high.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_ok_o <= 1'b0;
        else        frame_ok_o <= cs_rise && (cnt_q == CNT_W'(FRAME_W));
    end

    assign frame_o = rx_q;
    assign miso_o  = cs_act & tx_q[FRAME_W-1];

    AST_FRAME_AT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok_o |-> cs_s[2]); // R5
    AST_MISO_HOLD_SCK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && sck_s[1] && sck_s[2] && $past(cs_act)) |-> $stable(miso_o)); // R9
endmodule

// File: rtl/pwm_spi_regfile.sv
// Module: pwm_spi_regfile
// Decodes a completed frame into a register write or a read request, holds
// the register map and builds the response for the next frame.
// Assumes frame_ok_i pulses for one cycle with frame_i stable.
module pwm_spi_regfile
    import pwm_spi_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_ok_i,
    input  logic [FRAME_W-1:0]       frame_i,
    output logic [FRAME_W-1:0]       resp_o,
    output logic [DATA_W-1:0]        glob_o,
    output logic [DATA_W-1:0]        pol_o,
    output logic [DATA_W-1:0]        en_o,
    output logic [DATA_W-1:0]        wdog_o,
    output logic [N_CH-1:0][DATA_W-1:0] freq_o,
    output logic [N_CH-1:0][DATA_W-1:0] duty_o
);
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] wdata, rdata;
    logic wr, rd;
    logic [FRAME_W-1:0] resp_q;

    assign idx   = frame_i[FRAME_W-2:DATA_W];
    assign wdata = frame_i[DATA_W-1:0];
    assign wr    = frame_ok_i & frame_i[WR_BIT];
    assign rd    = ~frame_i[WR_BIT] & frame_i[RD_BIT];

    // Purpose: global, polarity, enable and watchdog registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_o <= '0;
            pol_o  <= '0;
            en_o   <= '0;
            wdog_o <= '0;
        end else if (wr) begin
            if (idx == IDX_GLOBAL)   glob_o <= wdata;
            if (idx == IDX_POLARITY) pol_o  <= wdata;
            if (idx == IDX_ENABLE)   en_o   <= wdata;
            if (idx == IDX_WATCHDOG) wdog_o <= wdata;
        end
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        // Purpose: per-channel frequency and duty codes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                freq_o[c] <= '0;
                duty_o[c] <= '0;
            end else if (wr) begin
                if (idx == IDX_FREQ_BASE + IDX_W'(c)) freq_o[c] <= wdata;
                if (idx == IDX_DUTY_BASE + IDX_W'(c)) duty_o[c] <= wdata;
            end
        end
    end

    // Purpose: read multiplexer, zero for unmapped indices.
    always_comb begin
        rdata = '0;
        if (idx == IDX_GLOBAL)   rdata = glob_o;
        if (idx == IDX_POLARITY) rdata = pol_o;
        if (idx == IDX_ENABLE)   rdata = en_o;
        if (idx == IDX_WATCHDOG) rdata = wdog_o;
        for (int c = 0; c < N_CH; c++) begin
            if (idx == IDX_FREQ_BASE + IDX_W'(c)) rdata = freq_o[c];
            if (idx == IDX_DUTY_BASE + IDX_W'(c)) rdata = duty_o[c];
        end
    end

    // Purpose: response word for the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          resp_q <= '0;
        else if (frame_ok_i) resp_q <= rd ? FRAME_W'(rdata) : '0;
    end

    assign resp_o = resp_q;

    logic [(4 + 2*N_CH)*DATA_W-1:0] all_regs;
    assign all_regs = {glob_o, pol_o, en_o, wdog_o, freq_o, duty_o};

    AST_REG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(all_regs) |-> $past(frame_ok_i && frame_i[WR_BIT])); // R2
    AST_RESP_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        resp_o[FRAME_W-1:RESP_W] == '0); // R3
    AST_NONREAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok_i && !rd) |=> resp_o == '0); // R4
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok_i && rd && idx == 7'h7F) |=> resp_o == '0); // R6
endmodule

// File: rtl/pwm_spi_regs.sv
// Module: pwm_spi_regs (top)
// SPI mode-0 slave giving register access to a four-channel PWM stage.
// Assumes SCLK at most a quarter of clk; one 16-bit frame per select window.
module pwm_spi_regs
    import pwm_spi_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   spi_sck,
    input  logic                   spi_cs_n,
    input  logic                   spi_mosi,
    output logic                   spi_miso,
    output logic [1:0]             mode_o,
    output logic                   normal_o,
    output logic [N_CH-1:0]        pol_inv_o,
    output logic [N_CH-1:0]        ch_en_o,
    output logic [N_CH*DATA_W-1:0] freq_o,
    output logic [N_CH*DATA_W-1:0] duty_o,
    output logic [DATA_W-1:0]      wdog_o
);
    logic frame_ok;
    logic [FRAME_W-1:0] frame, resp;
    logic [DATA_W-1:0] glob_q, pol_q, en_q;
    logic [N_CH-1:0][DATA_W-1:0] freq_q, duty_q;

    pwm_spi_shifter i_shifter (
        .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .cs_n_i(spi_cs_n),
        .mosi_i(spi_mosi), .resp_i(resp), .miso_o(spi_miso),
        .frame_ok_o(frame_ok), .frame_o(frame)
    );

    pwm_spi_regfile i_regfile (
        .clk(clk), .rst_n(rst_n), .frame_ok_i(frame_ok), .frame_i(frame),
        .resp_o(resp), .glob_o(glob_q), .pol_o(pol_q), .en_o(en_q),
        .wdog_o(wdog_o), .freq_o(freq_q), .duty_o(duty_q)
    );

    assign mode_o    = glob_q[DATA_W-1:DATA_W-2];
    assign normal_o  = (mode_o == MODE_NORMAL);
    assign pol_inv_o = pol_q[N_CH-1:0];
    assign ch_en_o   = en_q[2*N_CH-1:N_CH];
    assign freq_o    = freq_q;
    assign duty_o    = duty_q;

    AST_DESELECT_MISO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3) |-> !spi_miso); // R1
endmodule

// File: tb/test_pwm_spi_regs.sv
module test_pwm_spi_regs;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, normal;
    logic [1:0] mode;
    logic [3:0] pol, en;
    logic [31:0] freq, duty;
    logic [7:0] wdog;
    int checks = 0, fails = 0;
    logic [15:0] rx;

    always #5 clk = ~clk;

    pwm_spi_regs i_pwm_spi_regs (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .mode_o(mode), .normal_o(normal),
        .pol_inv_o(pol), .ch_en_o(en), .freq_o(freq), .duty_o(duty),
        .wdog_o(wdog)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift nbits of word (MSB first); capture MISO before each rising edge.
    task automatic xfer(input logic [15:0] w, input int nbits, output logic [15:0] r);
        logic [31:0] ext;
        ext = {w, 16'h0};
        r = '0;
        cs_n = 1'b0;
        wait_clk(6);
        for (int i = 0; i < nbits; i++) begin
            mosi = ext[31 - i];
            wait_clk(4);
            if (i < 16) r[15 - i] = miso;
            sck = 1'b1;
            wait_clk(4);
            sck = 1'b0;
        end
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic wr(input logic [6:0] idx, input logic [7:0] d);
        logic [15:0] r;
        xfer({1'b1, idx, d}, 16, r);
    endtask

    task automatic t_reset;
        chk("R1 mode", mode, 0);      chk("R1 normal", normal, 0);
        chk("R1 pol", pol, 0);        chk("R1 en", en, 0);
        chk("R1 freq", freq, 0);      chk("R1 duty", duty, 0);
        chk("R1 wdog", wdog, 0);      chk("R1 miso", miso, 0);
    endtask

    task automatic t_write_map;
        wr(7'h00, 8'h40);
        chk("R8 mode", mode, 1);  chk("R8 normal", normal, 1);
        wr(7'h00, 8'hC0);
        chk("R8 mode3", mode, 3); chk("R8 normal off", normal, 0);
        wr(7'h05, 8'hA5);
        chk("R7 pol", pol, 4'h5);
        wr(7'h07, 8'h5A);
        chk("R7 en", en, 4'h5);
        for (int c = 0; c < 4; c++) begin
            wr(7'h08 + 7'(c), 8'h10 + 8'(c));
            wr(7'h0C + 7'(c), 8'h80 + 8'(c));
        end
        chk("R10 freq", freq, 32'h13121110);
        chk("R11 R10 duty", duty, 32'h83828180);
        wr(7'h14, 8'h3C);
        chk("R2 wdog", wdog, 8'h3C);
    endtask

    task automatic t_read_chain;
        xfer({8'h0A, 8'h80}, 16, rx);
        xfer({8'h0D, 8'h80}, 16, rx);
        chk("R3 R9 read freq ch3", rx, 16'h0012);
        xfer({8'h07, 8'hFF}, 16, rx);
        chk("R3 read duty ch2", rx, 16'h0081);
        xfer({8'h85, 8'h0F}, 16, rx);
        chk("R3 read enable", rx, 16'h005A);
        chk("R2 pol rewrite", pol, 4'hF);
        xfer(16'h0000, 16, rx);
        chk("R4 after write", rx, 16'h0000);
        xfer({8'h14, 8'h80}, 16, rx);
        chk("R4 after noop", rx, 16'h0000);
        xfer(16'h0000, 16, rx);
        chk("R3 read wdog", rx, 16'h003C);
    endtask

    task automatic t_unmapped;
        wr(7'h03, 8'hFF);
        wr(7'h7F, 8'hFF);
        chk("R6 en kept", en, 4'h5);
        chk("R6 pol kept", pol, 4'hF);
        chk("R6 freq kept", freq, 32'h13121110);
        chk("R6 duty kept", duty, 32'h83828180);
        chk("R6 mode kept", mode, 3);
        xfer({8'h03, 8'h80}, 16, rx);
        xfer({8'h7F, 8'h80}, 16, rx);
        chk("R6 read 0x03", rx, 16'h0000);
        xfer(16'h0000, 16, rx);
        chk("R6 read 0x7F", rx, 16'h0000);
    endtask

    task automatic t_bad_len;
        xfer({8'h0C, 8'h80}, 16, rx);
        xfer({8'h80, 8'h00}, 12, rx);
        chk("R5 short no write", mode, 3);
        xfer({8'h88, 8'hEE}, 20, rx);
        chk("R5 long no write", freq[7:0], 8'h10);
        xfer(16'h0000, 16, rx);
        chk("R5 response kept", rx, 16'h0080);
    endtask

    initial begin
        wait_clk(5);
        t_reset;
        rst_n = 1'b1;
        wait_clk(3);
        t_reset;
        t_write_map;
        t_read_chain;
        t_unmapped;
        t_bad_len;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule